// File: doc/BRIEF.md
# Descriptor-Driven I/O Channel Processor

This block is a small I/O channel engine placed between a shared memory bus and a group of attached peripherals. The CPU launches a job with one short command. The command carries an operation code, a device number and a pointer to a four-word job descriptor held in main memory. The engine fetches the descriptor by itself and then moves the requested number of words between the chosen device and a memory buffer. It takes the memory bus for one word at a time, so the CPU can win the bus between words. When the job ends, it raises an interrupt.

The descriptor is four consecutive 32-bit words at increasing addresses. Word 0 is the operation word: bit 0 is the direction, where 1 means device-to-memory and 0 means memory-to-device. Word 1 is the buffer word address. Word 2 is the word count. Word 3 is the options word: bit 0 holds the buffer address fixed instead of stepping it. The control is a single state machine with these states:
- `S_IDLE`: waits for a command.
- `S_DESC_REQ` / `S_DESC_GAP`: fetch the descriptor words with a one-cycle gap after each grant.
- `S_CHECK`: tests for a zero count and picks the direction.
- `S_DEV_WAIT` → `S_MEM_WR`: device-to-memory path.
- `S_MEM_RD` → `S_DEV_PUT`: memory-to-device path.
- `S_STEP`: updates the buffer address and the count, then either loops back or leaves.
- `S_DONE`: holds the interrupt until it is acknowledged.

The transitions are as follows. From `S_IDLE`, an accepted command goes to `S_DESC_REQ`, or straight to `S_DONE` for a bad device number. `S_DESC_REQ` moves to `S_DESC_GAP` on a grant. `S_DESC_GAP` returns to `S_DESC_REQ` until four words are latched, then goes to `S_CHECK`. `S_CHECK` goes to `S_DONE` on a zero count, otherwise to `S_DEV_WAIT` or `S_MEM_RD`. `S_DEV_WAIT` goes to `S_MEM_WR` when the device presents a word. `S_MEM_WR` goes to `S_STEP` on a grant. `S_MEM_RD` goes to `S_DEV_PUT` on a grant. `S_DEV_PUT` goes to `S_STEP` when the device accepts the word. `S_STEP` goes to `S_DONE` after the last word, otherwise back to `S_DEV_WAIT` or `S_MEM_RD`. `S_DONE` returns to `S_IDLE` on acknowledge.

Top module: `io_channel_proc`

## Requirements
- R1: After reset, `busy`, `irq`, `err` and `mem_req` are 0, and no device sees a ready or valid strobe.
- R2: A command is accepted only when `cmd_valid` is 1 and `cmd_op` equals 2'b01. Any other op code is ignored: `busy` stays 0 and no memory access occurs.
- R3: A command that arrives while `busy` is 1 is ignored. `busy` reads 1, and the running job completes unchanged.
- R4: After an accepted command with a valid device, the engine first reads exactly four words at `cmd_ptr`, `cmd_ptr`+1, `cmd_ptr`+2 and `cmd_ptr`+3 in that order, before any data access.
- R5: `mem_req` stays high with a stable address and direction until `mem_gnt`. In the cycle after a granted access, `mem_req` is low.
- R6: With direction bit 0 of descriptor word 0 set to 1, each memory write carries the word the selected device presented. The write is issued only after the device handshake for that word.
- R7: With direction bit 0 set to 0, each word read from memory is offered to the selected device with valid held stable until ready. The next memory read is issued only after the device accepts the current word.
- R8: Exactly count words (descriptor word 2) are moved. The buffer address (word 1) rises by one per word.
- R9: With bit 0 of descriptor word 3 set to 1, every data access of the job uses the buffer address from word 1.
- R10: A zero count ends the job with the interrupt after the four descriptor reads and no data cycles.
- R11: `irq` stays 1 until `irq_ack` is pulsed. After the acknowledge, `irq` and `busy` drop to 0 in the next cycle.
- R12: A device number not below the number of attached devices causes no memory or device activity, sets `err` to 1 and raises `irq`. The next good command clears `err`.
- R13: Only the device named by the command sees ready or valid strobes, and never both directions at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe from the CPU |
| cmd_op | input | 2 | Command operation code (2'b01 starts a job) |
| cmd_dev | input | DEV_W | Target device number |
| cmd_ptr | input | AW | Word address of the descriptor |
| busy | output | 1 | Job in progress or interrupt pending |
| err | output | 1 | Last accepted command named a missing device |
| irq | output | 1 | Completion interrupt |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| mem_req | output | 1 | Memory bus request for one word |
| mem_we | output | 1 | 1 for a memory write |
| mem_gnt | input | 1 | Memory bus grant, access completes in this cycle |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with the grant |
| dev_in_data | input | NDEV*DW | Per-device words toward memory |
| dev_in_valid | input | NDEV | Per-device word present |
| dev_in_ready | output | NDEV | Per-device word taken |
| dev_out_data | output | DW | Word offered to devices |
| dev_out_valid | output | NDEV | Per-device word offered |
| dev_out_ready | input | NDEV | Per-device word accepted |

## Verification
Jobs run in both directions with immediate grants and ready signals, then with a memory that grants only every third cycle and devices that stall on alternate cycles. These runs show that data and ordering do not depend on handshake timing. Held-address jobs are set against stepping jobs so an address that fails to step or fails to hold shows up in the write and read addresses. Zero-count, missing-device, wrong-op-code and mid-job commands each leave a distinct footprint in the read log, the write count and the `err` flag.

// File: rtl/iochan_pkg.sv
package iochan_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DESC_REQ,
        S_DESC_GAP,
        S_CHECK,
        S_DEV_WAIT,
        S_MEM_WR,
        S_MEM_RD,
        S_DEV_PUT,
        S_STEP,
        S_DONE
    } chan_state_e;

    localparam int          DESC_WORDS   = 4;
    localparam int          CMD_OP_W     = 2;
    localparam logic [1:0]  CMD_GO       = 2'b01;
    localparam int          DESC_DIR_BIT = 0;   // word 0: 1 = device to memory
    localparam int          OPT_HOLD_BIT = 0;   // word 3: 1 = fixed buffer address

endpackage

// File: rtl/iochan_ctrl.sv
module iochan_ctrl
    import iochan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_ok,
    input  logic        dev_bad,
    input  logic        mem_gnt,
    input  logic        desc_done,
    input  logic        cnt_zero,
    input  logic        cnt_one,
    input  logic        dir_in,
    input  logic        sel_valid,
    input  logic        sel_ready,
    input  logic        irq_ack,
    output chan_state_e state,
    output logic        mem_req,
    output logic        mem_we,
    output logic        want_in,
    output logic        want_out,
    output logic        busy,
    output logic        irq
);

    chan_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (start_ok) nxt = dev_bad ? S_DONE : S_DESC_REQ;
            S_DESC_REQ: if (mem_gnt) nxt = S_DESC_GAP;
            S_DESC_GAP: nxt = desc_done ? S_CHECK : S_DESC_REQ;
            S_CHECK: begin
                if (cnt_zero) nxt = S_DONE;
                else          nxt = dir_in ? S_DEV_WAIT : S_MEM_RD;
            end
            S_DEV_WAIT: if (sel_valid) nxt = S_MEM_WR;
            S_MEM_WR:   if (mem_gnt) nxt = S_STEP;
            S_MEM_RD:   if (mem_gnt) nxt = S_DEV_PUT;
            S_DEV_PUT:  if (sel_ready) nxt = S_STEP;
            S_STEP: begin
                if (cnt_one) nxt = S_DONE;
                else         nxt = dir_in ? S_DEV_WAIT : S_MEM_RD;
            end
            S_DONE:     if (irq_ack) nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        want_in  = 1'b0;
        want_out = 1'b0;
        irq      = 1'b0;
        busy     = (state != S_IDLE);
        unique case (state)
            S_DESC_REQ: mem_req = 1'b1;
            S_MEM_RD:   mem_req = 1'b1;
            S_MEM_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            S_DEV_WAIT: want_in  = 1'b1;
            S_DEV_PUT:  want_out = 1'b1;
            S_DONE:     irq      = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/iochan_dp.sv
module iochan_dp
    import iochan_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int DEV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  chan_state_e      state,
    input  logic             start_ok,
    input  logic [DEV_W-1:0] cmd_dev,
    input  logic [AW-1:0]    cmd_ptr,
    input  logic             dev_bad,
    input  logic             mem_gnt,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             sel_valid,
    input  logic [DW-1:0]    sel_word,
    output logic [DEV_W-1:0] dev_q,
    output logic             dir_q,
    output logic             cnt_zero,
    output logic             cnt_one,
    output logic             desc_done,
    output logic             err_q,
    output logic [DW-1:0]    word_q,
    output logic [AW-1:0]    mem_addr
);

    localparam int IDX_W = $clog2(DESC_WORDS + 1);

    logic [AW-1:0]    ptr_q;
    logic [AW-1:0]    buf_q;
    logic [CW-1:0]    cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic             hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_q  <= '0;
            ptr_q  <= '0;
            buf_q  <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
            dir_q  <= 1'b0;
            hold_q <= 1'b0;
            err_q  <= 1'b0;
            word_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start_ok) begin
                        dev_q <= cmd_dev;
                        ptr_q <= cmd_ptr;
                        idx_q <= '0;
                        err_q <= dev_bad;
                    end
                end
                S_DESC_REQ: begin
                    if (mem_gnt) begin
                        ptr_q <= ptr_q + 1'b1;
                        idx_q <= idx_q + 1'b1;
                        case (idx_q)
                            IDX_W'(0): dir_q  <= mem_rdata[DESC_DIR_BIT];
                            IDX_W'(1): buf_q  <= mem_rdata[AW-1:0];
                            IDX_W'(2): cnt_q  <= mem_rdata[CW-1:0];
                            default:   hold_q <= mem_rdata[OPT_HOLD_BIT];
                        endcase
                    end
                end
                S_DEV_WAIT: if (sel_valid) word_q <= sel_word;
                S_MEM_RD:   if (mem_gnt) word_q <= mem_rdata;
                S_STEP: begin
                    cnt_q <= cnt_q - 1'b1;
                    if (!hold_q) buf_q <= buf_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign cnt_zero  = (cnt_q == '0);
    assign cnt_one   = (cnt_q == CW'(1));
    assign desc_done = (idx_q == IDX_W'(DESC_WORDS));
    assign mem_addr  = (state == S_DESC_REQ) ? ptr_q : buf_q;

endmodule

// File: rtl/iochan_devsel.sv
module iochan_devsel #(
    parameter int NDEV  = 3,
    parameter int DW    = 32,
    parameter int DEV_W = 2
) (
    input  logic [DEV_W-1:0]   dev_sel,
    input  logic               want_in,
    input  logic               want_out,
    input  logic [NDEV*DW-1:0] dev_in_data,
    input  logic [NDEV-1:0]    dev_in_valid,
    input  logic [NDEV-1:0]    dev_out_ready,
    output logic [NDEV-1:0]    dev_in_ready,
    output logic [NDEV-1:0]    dev_out_valid,
    output logic               sel_valid,
    output logic               sel_ready,
    output logic [DW-1:0]      sel_word
);

    logic [NDEV-1:0] hit;

    for (genvar g = 0; g < NDEV; g++) begin : g_lane
        assign hit[g]           = (dev_sel == DEV_W'(g));
        assign dev_in_ready[g]  = want_in  & hit[g];
        assign dev_out_valid[g] = want_out & hit[g];
    end

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NDEV; i++) begin
            if (hit[i]) sel_word = dev_in_data[i*DW +: DW];
        end
    end

    assign sel_valid = |(hit & dev_in_valid);
    assign sel_ready = |(hit & dev_out_ready);

endmodule

// File: rtl/io_channel_proc.sv
module io_channel_proc
    import iochan_pkg::*;
#(
    parameter int NDEV  = 3,
    parameter int DW    = 32,
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int DEV_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [DEV_W-1:0]   cmd_dev,
    input  logic [AW-1:0]      cmd_ptr,
    output logic               busy,
    output logic               err,
    output logic               irq,
    input  logic               irq_ack,
    output logic               mem_req,
    output logic               mem_we,
    input  logic               mem_gnt,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      mem_rdata,
    input  logic [NDEV*DW-1:0] dev_in_data,
    input  logic [NDEV-1:0]    dev_in_valid,
    output logic [NDEV-1:0]    dev_in_ready,
    output logic [DW-1:0]      dev_out_data,
    output logic [NDEV-1:0]    dev_out_valid,
    input  logic [NDEV-1:0]    dev_out_ready
);

    chan_state_e      state;
    logic             start_ok, dev_bad;
    logic             desc_done, cnt_zero, cnt_one, dir_q;
    logic             want_in, want_out, sel_valid, sel_ready;
    logic [DEV_W-1:0] dev_q;
    logic [DW-1:0]    sel_word, word_q;

    assign start_ok = cmd_valid && (cmd_op == CMD_GO);
    assign dev_bad  = (int'(cmd_dev) >= NDEV);

    iochan_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_ok  (start_ok),
        .dev_bad   (dev_bad),
        .mem_gnt   (mem_gnt),
        .desc_done (desc_done),
        .cnt_zero  (cnt_zero),
        .cnt_one   (cnt_one),
        .dir_in    (dir_q),
        .sel_valid (sel_valid),
        .sel_ready (sel_ready),
        .irq_ack   (irq_ack),
        .state     (state),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .want_in   (want_in),
        .want_out  (want_out),
        .busy      (busy),
        .irq       (irq)
    );

    iochan_dp #(.DW(DW), .AW(AW), .CW(CW), .DEV_W(DEV_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .start_ok  (start_ok),
        .cmd_dev   (cmd_dev),
        .cmd_ptr   (cmd_ptr),
        .dev_bad   (dev_bad),
        .mem_gnt   (mem_gnt),
        .mem_rdata (mem_rdata),
        .sel_valid (sel_valid),
        .sel_word  (sel_word),
        .dev_q     (dev_q),
        .dir_q     (dir_q),
        .cnt_zero  (cnt_zero),
        .cnt_one   (cnt_one),
        .desc_done (desc_done),
        .err_q     (err),
        .word_q    (word_q),
        .mem_addr  (mem_addr)
    );

    iochan_devsel #(.NDEV(NDEV), .DW(DW), .DEV_W(DEV_W)) u_sel (
        .dev_sel       (dev_q),
        .want_in       (want_in),
        .want_out      (want_out),
        .dev_in_data   (dev_in_data),
        .dev_in_valid  (dev_in_valid),
        .dev_out_ready (dev_out_ready),
        .dev_in_ready  (dev_in_ready),
        .dev_out_valid (dev_out_valid),
        .sel_valid     (sel_valid),
        .sel_ready     (sel_ready),
        .sel_word      (sel_word)
    );

    assign mem_wdata    = word_q;
    assign dev_out_data = word_q;

endmodule

// File: rtl/iochan_chk.sv
module iochan_chk #(
    parameter int NDEV = 3,
    parameter int DW   = 32,
    parameter int AW   = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            err,
    input logic            irq,
    input logic            irq_ack,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_gnt,
    input logic [AW-1:0]   mem_addr,
    input logic [NDEV-1:0] dev_in_ready,
    input logic [NDEV-1:0] dev_out_valid,
    input logic [NDEV-1:0] dev_out_ready,
    input logic [DW-1:0]   dev_out_data
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !irq));

    p_err_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(err));

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> !mem_req);

    p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dev_out_valid) && !(|(dev_out_valid & dev_out_ready)))
            |=> ($stable(dev_out_valid) && $stable(dev_out_data)));

    p_rd_no_offer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !(|dev_out_valid));

    p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    p_irq_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_ack) |=> (!irq && !busy));

    p_bad_dev_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!mem_req && !(|dev_in_ready) && !(|dev_out_valid)));

    p_one_lane_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_in_ready) && $onehot0(dev_out_valid));

    p_one_dir_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !((|dev_in_ready) && (|dev_out_valid)));

endmodule

bind io_channel_proc iochan_chk #(.NDEV(NDEV), .DW(DW), .AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .err           (err),
    .irq           (irq),
    .irq_ack       (irq_ack),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_gnt       (mem_gnt),
    .mem_addr      (mem_addr),
    .dev_in_ready  (dev_in_ready),
    .dev_out_valid (dev_out_valid),
    .dev_out_ready (dev_out_ready),
    .dev_out_data  (dev_out_data)
);

// File: tb/io_channel_proc_test.sv
module io_channel_proc_test;

    localparam int NDEV  = 3;
    localparam int DW    = 32;
    localparam int AW    = 16;
    localparam int DEV_W = 2;

    typedef struct packed {
        logic        kind;   // 0 = memory write, 1 = device output
        logic [1:0]  dev;
        logic [15:0] addr;
        logic [31:0] data;
    } item_t;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               cmd_valid;
    logic [1:0]         cmd_op;
    logic [DEV_W-1:0]   cmd_dev;
    logic [AW-1:0]      cmd_ptr;
    logic               busy, err, irq, irq_ack;
    logic               mem_req, mem_we, mem_gnt;
    logic [AW-1:0]      mem_addr;
    logic [DW-1:0]      mem_wdata, mem_rdata;
    logic [NDEV*DW-1:0] dev_in_data;
    logic [NDEV-1:0]    dev_in_valid, dev_in_ready;
    logic [DW-1:0]      dev_out_data;
    logic [NDEV-1:0]    dev_out_valid, dev_out_ready;

    logic [31:0] mem [0:255];
    item_t       exp_q[$];
    logic [31:0] src_q[$];
    logic [15:0] rd_log[$];
    int  n_chk = 0, n_fail = 0;
    int  cyc = 0, cur_dev = 0, wr_cnt = 0, in_acc = 0, out_acc = 0, stray = 0;
    bit  slow = 0, in_v = 0, took = 0;

    always #5 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];

    io_channel_proc uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_dev(cmd_dev), .cmd_ptr(cmd_ptr), .busy(busy), .err(err), .irq(irq),
        .irq_ack(irq_ack), .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_in_data(dev_in_data), .dev_in_valid(dev_in_valid),
        .dev_in_ready(dev_in_ready), .dev_out_data(dev_out_data),
        .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready)
    );

    function automatic void chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endfunction

    function automatic void take(item_t got);
        item_t e;
        if (exp_q.size() == 0) begin
            chk("R8", "unexpected transfer", 64'(got), 64'h0);
            return;
        end
        e = exp_q.pop_front();
        chk(got.kind ? "R7" : "R6", "scoreboard item", 64'(got), 64'(e));
    endfunction

    // monitor: memory model, scoreboard compare, handshake bookkeeping
    always @(posedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mem_req && mem_gnt) begin
                if (mem_we) begin
                    chk("R6", "write follows device word", 64'(in_acc), 64'(wr_cnt + 1));
                    mem[mem_addr[7:0]] = mem_wdata;
                    wr_cnt++;
                    take('{kind: 1'b0, dev: 2'(cur_dev), addr: mem_addr, data: mem_wdata});
                end else begin
                    if (rd_log.size() >= 4)
                        chk("R7", "read waits for accept", 64'(out_acc), 64'(rd_log.size() - 4));
                    rd_log.push_back(mem_addr);
                end
            end
            for (int d = 0; d < NDEV; d++) begin
                if (dev_out_valid[d] && dev_out_ready[d]) begin
                    out_acc++;
                    take('{kind: 1'b1, dev: 2'(d), addr: 16'h0, data: dev_out_data});
                end
                if (d != cur_dev && (dev_in_ready[d] || dev_out_valid[d])) stray++;
            end
            if (cur_dev < NDEV && dev_in_valid[cur_dev] && dev_in_ready[cur_dev]) begin
                void'(src_q.pop_front());
                in_acc++;
                took = 1'b1;
            end
        end
    end

    // drivers for the memory grant and the device side, away from the active edge
    always @(negedge clk) begin
        mem_gnt       = mem_req && (!slow || (cyc % 3 == 0));
        dev_out_ready = slow ? {NDEV{cyc[0]}} : '1;
        if (src_q.size() == 0)  in_v = 1'b0;
        else if (!in_v || took) in_v = !slow || cyc[1];
        took = 1'b0;
        dev_in_valid = '0;
        if (in_v && cur_dev < NDEV) dev_in_valid[cur_dev] = 1'b1;
        for (int i = 0; i < NDEV; i++)
            dev_in_data[i*DW +: DW] = (i == cur_dev && src_q.size() != 0) ? src_q[0]
                                                                           : (32'hBAD0_0000 | i);
    end

    task automatic clear_logs();
        rd_log.delete(); exp_q.delete(); src_q.delete();
        wr_cnt = 0; in_acc = 0; out_acc = 0; stray = 0;
    endtask

    task automatic send_cmd(logic [1:0] op, int dev, int ptr);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_dev = DEV_W'(dev); cmd_ptr = AW'(ptr);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic ack_irq(string req);
        repeat (3) @(negedge clk);
        chk(req, "irq held before ack", 64'(irq), 64'h1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R11", "irq cleared by ack", 64'(irq), 64'h0);
        chk("R11", "busy cleared by ack", 64'(busy), 64'h0);
    endtask

    task automatic run_job(int dev, int ptr, bit dir, int bufa, int cnt, bit hold,
                           logic [31:0] seed, bit sl, bit poke, string req);
        int a;
        clear_logs();
        slow = sl; cur_dev = dev;
        mem[ptr]   = 32'hA5A5_0000 | 32'(dir);
        mem[ptr+1] = 32'(bufa);
        mem[ptr+2] = 32'(cnt);
        mem[ptr+3] = 32'hFFFF_FFF0 | 32'(hold);
        for (int i = 0; i < cnt; i++) mem[bufa+i] = seed ^ (32'(i) * 32'h0101_0101);
        for (int i = 0; i < cnt; i++) begin
            a = hold ? bufa : bufa + i;
            if (dir) begin
                src_q.push_back(seed + 32'(i) * 7);
                exp_q.push_back('{kind: 1'b0, dev: 2'(dev), addr: 16'(a), data: seed + 32'(i) * 7});
            end else begin
                exp_q.push_back('{kind: 1'b1, dev: 2'(dev), addr: 16'h0, data: mem[a]});
            end
        end
        send_cmd(2'b01, dev, ptr);
        if (poke) begin
            repeat (4) @(negedge clk);
            chk("R3", "busy during job", 64'(busy), 64'h1);
            send_cmd(2'b01, (dev + 1) % NDEV, 200);
            chk("R3", "busy after second command", 64'(busy), 64'h1);
        end
        while (!irq) @(negedge clk);
        chk(req, "all expected items seen", 64'(exp_q.size()), 64'h0);
        chk("R8", "memory reads", 64'(rd_log.size()), 64'(4 + (dir ? 0 : cnt)));
        chk("R8", "memory writes", 64'(wr_cnt), 64'(dir ? cnt : 0));
        for (int k = 0; k < 4 && k < rd_log.size(); k++)
            chk("R4", "descriptor read order", 64'(rd_log[k]), 64'(ptr + k));
        chk("R13", "strobes on other devices", 64'(stray), 64'h0);
        chk("R12", "err clear on good device", 64'(err), 64'h0);
        ack_irq("R11");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_dev = '0; cmd_ptr = '0;
        irq_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "busy", 64'(busy), 64'h0);
        chk("R1", "irq", 64'(irq), 64'h0);
        chk("R1", "err", 64'(err), 64'h0);
        chk("R1", "mem_req", 64'(mem_req), 64'h0);
        chk("R1", "device strobes", 64'({dev_in_ready, dev_out_valid}), 64'h0);

        // R2: wrong op code ignored
        clear_logs();
        send_cmd(2'b10, 0, 16);
        repeat (3) @(negedge clk);
        chk("R2", "busy after bad op", 64'(busy), 64'h0);
        chk("R2", "no reads after bad op", 64'(rd_log.size()), 64'h0);

        // R6 / R8: device to memory, fast and slow handshakes
        run_job(0, 16, 1'b1, 100, 5, 1'b0, 32'h1000_0000, 1'b0, 1'b0, "R6");
        run_job(2, 20, 1'b1, 110, 6, 1'b0, 32'h2000_0000, 1'b1, 1'b0, "R6");
        // R7 / R8: memory to device
        run_job(1, 24, 1'b0, 120, 4, 1'b0, 32'h3300_0001, 1'b0, 1'b0, "R7");
        run_job(0, 28, 1'b0, 130, 7, 1'b0, 32'h4400_0002, 1'b1, 1'b0, "R7");
        // R9: fixed buffer address in both directions
        run_job(1, 32, 1'b1, 140, 3, 1'b1, 32'h5500_0000, 1'b1, 1'b0, "R9");
        run_job(2, 36, 1'b0, 150, 3, 1'b1, 32'h6600_0000, 1'b0, 1'b0, "R9");
        // R10: zero count
        run_job(1, 40, 1'b1, 160, 0, 1'b0, 32'h0, 1'b0, 1'b0, "R10");
        // R3: second command during a running job
        run_job(2, 44, 1'b0, 170, 6, 1'b0, 32'h7700_0000, 1'b1, 1'b1, "R3");

        // R12: device number out of range
        clear_logs();
        cur_dev = 3;
        send_cmd(2'b01, 3, 48);
        while (!irq) @(negedge clk);
        chk("R12", "err set", 64'(err), 64'h1);
        chk("R12", "no memory reads", 64'(rd_log.size()), 64'h0);
        chk("R12", "no memory writes", 64'(wr_cnt), 64'h0);
        chk("R12", "no device strobes", 64'(stray), 64'h0);
        ack_irq("R12");
        // a good job afterwards clears err (checked inside run_job)
        run_job(0, 52, 1'b1, 180, 2, 1'b0, 32'h8800_0000, 1'b0, 1'b0, "R12");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule